// File: doc/BRIEF.md
# Receive DMA Channel Event and Interrupt Controller

This block collects the event conditions of one receive DMA channel and turns them into an interrupt and a channel-reset request. Each of 22 event inputs is caught in a sticky status bit. A per-event mask word decides which status bits count as active. Events are split into two classes. Recoverable events can be cleared one by one by software. Fatal events stay set until the whole channel is reset, and while any of them is active a dedicated output is driven.

Interrupt delivery is one-shot. An arm bit lets the interrupt line rise while any unmasked event is pending. On the first clock edge where the line is high, the arm bit drops by itself. Software therefore clears the events it has handled and then re-arms with a second, separate write. A write to the config word starts a timed channel reset. While that reset runs, the block holds all status clear, forces the mask to all ones, disarms, and ignores events and register writes.

Software reaches the block through a flat register port. Writes are single-cycle strobes. Reads are combinational on the address.

Top module: `rxch_intr_ctl`

## Requirements
- R1: An `evt_i[i]` bit that is high at a clock edge sets status bit i, for i other than 15. The bit stays set afterwards. Status bit i reads at bit 32+i of register word 0.
- R2: The mask word at address 1 holds one bit per event in bits 21:0. A 1 suppresses the event and a 0 enables it. An event is active only when its status bit is 1 and its mask bit is 0.
- R3: `fatal_o` is high exactly while an active event has index 0, 1, 2, 4, 5, 6, 11, 12, 17, 18, 19, 20 or 21.
- R4: A write to address 0 with `reg_mode_i`=1 clears every recoverable status bit (indices 3, 7, 8, 9, 10, 13, 14, 16) whose bit 32+i is 1. Fatal status bits and bits written with 0 do not change.
- R5: If an event and a clear reach the same status bit in the same cycle, the event wins and the bit stays set.
- R6: A write to address 0 with `reg_mode_i`=0 and bit 47 set sets the arm bit, which reads at bit 47. Mode-0 writes to status bits, mode-1 writes to bit 47, and `evt_i[15]` all have no effect.
- R7: `irq_o` is high while the arm bit is 1 and at least one event is active. At each edge where `irq_o` is high, the arm bit clears, unless the same edge performs an arm write.
- R8: Writing 1 to bit 30 at address 2 drives `chan_rst_o` high for RST_CYCLES (default 100) cycles, and bit 30 reads 1 during that time. Writing 0 to bit 30 has no effect.
- R9: During a channel reset, status and the arm bit clear, the mask becomes all ones, and events and register writes are ignored.
- R10: After `rst_ni` is asserted, status and the arm bit are 0, the mask is all ones, and `chan_rst_o` and `irq_o` are 0. Address 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| evt_i | input | 22 | Event strobes, one per event index |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Word select: 0 control/status, 1 mask, 2 config |
| reg_mode_i | input | 1 | Control/status write mode: 0 set control bits, 1 write-one-to-clear |
| reg_wdata_i | input | 64 | Write data |
| reg_rdata_o | output | 64 | Read data for `reg_addr_i` |
| irq_o | output | 1 | Channel interrupt |
| fatal_o | output | 1 | An active fatal event is pending |
| chan_rst_o | output | 1 | Channel reset in progress |

## Verification
The hardest situations to reach from the ports are two collisions. In the first, a hardware event lands on a status bit in the same cycle as a software clear of that bit. The bench produces it by raising the event strobe and the clear write on the same falling edge, so that both reach the same rising edge. In the second, event strobes and register writes arrive inside the reset window. The bench produces it by injecting them while it counts the cycles of `chan_rst_o`, and then checks that nothing of them survives the reset. The one-shot arm bit is checked by sampling `irq_o` in the cycle right after the event, in the cycle after that, and again after a re-arm with the event still pending.

// File: rtl/rxch_pkg.sv
package rxch_pkg;
  localparam int unsigned REG_W    = 64;
  localparam int unsigned N_EVT    = 22;
  localparam int unsigned ARM_IDX  = 15;
  localparam int unsigned STAT_LSB = 32;
  localparam int unsigned RST_BIT  = 30;

  localparam logic [N_EVT-1:0] FATAL_SET  = 22'h3E1877;
  localparam logic [N_EVT-1:0] ARM_ONEHOT = {{(N_EVT-1){1'b0}}, 1'b1} << ARM_IDX;
  localparam logic [N_EVT-1:0] CLR_SET    = ~FATAL_SET & ~ARM_ONEHOT;

  typedef enum logic [1:0] {
    ADDR_CTL  = 2'd0,
    ADDR_MASK = 2'd1,
    ADDR_CFG  = 2'd2
  } reg_sel_e;

  typedef enum logic {
    MODE_SET = 1'b0,
    MODE_CLR = 1'b1
  } wr_mode_e;
endpackage

// File: rtl/rxch_status_bank.sv
module rxch_status_bank
  import rxch_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_EVT-1:0] evt_i,
  input  logic [N_EVT-1:0] clr_i,
  input  logic             hold_i,
  output logic [N_EVT-1:0] status_o
);
  for (genvar i = 0; i < int'(N_EVT); i++) begin : g_bit
    if (i == int'(ARM_IDX)) begin : g_arm_slot
      // slot belongs to the arm control, never a status flop
      assign status_o[i] = 1'b0;
    end else begin : g_flop
      logic q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     q <= 1'b0;
        else if (hold_i) q <= 1'b0;
        else             q <= (q & ~clr_i[i]) | evt_i[i];  // event beats clear
      end
      assign status_o[i] = q;
    end
  end
endmodule

// File: rtl/rxch_arm_ctl.sv
module rxch_arm_ctl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic hold_i,
  input  logic active_any_i,
  output logic arm_o,
  output logic irq_o
);
  logic arm_q;

  assign irq_o = arm_q & active_any_i;
  assign arm_o = arm_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     arm_q <= 1'b0;
    else if (hold_i) arm_q <= 1'b0;
    else if (set_i)  arm_q <= 1'b1;
    else if (irq_o)  arm_q <= 1'b0;  // one-shot
  end
endmodule

// File: rtl/rxch_rst_seq.sv
module rxch_rst_seq #(
  parameter int unsigned RST_CYCLES = 100
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o
);
  localparam int unsigned CNT_W = $clog2(RST_CYCLES + 1);

  logic [CNT_W-1:0] cnt_q;

  assign busy_o = (cnt_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (busy_o)             cnt_q <= cnt_q - 1'b1;
    else if (start_i)            cnt_q <= CNT_W'(RST_CYCLES);
  end
endmodule

// File: rtl/rxch_intr_ctl.sv
module rxch_intr_ctl
  import rxch_pkg::*;
#(
  parameter int unsigned RST_CYCLES = 100
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_EVT-1:0] evt_i,
  input  logic             reg_wr_i,
  input  logic [1:0]       reg_addr_i,
  input  logic             reg_mode_i,
  input  logic [REG_W-1:0] reg_wdata_i,
  output logic [REG_W-1:0] reg_rdata_o,
  output logic             irq_o,
  output logic             fatal_o,
  output logic             chan_rst_o
);
  logic             busy;
  logic             wr_ok;
  logic             ctl_wr;
  logic             arm_set;
  logic             rst_start;
  logic [N_EVT-1:0] stat_clr;
  logic [N_EVT-1:0] evt_eff;
  logic [N_EVT-1:0] status_q;
  logic [N_EVT-1:0] mask_q;
  logic [N_EVT-1:0] active;
  logic             arm_q;

  // write decode; everything is locked out while the channel resets
  assign wr_ok     = reg_wr_i & ~busy;
  assign ctl_wr    = wr_ok & (reg_addr_i == ADDR_CTL);
  assign stat_clr  = (ctl_wr && reg_mode_i == MODE_CLR)
                   ? (reg_wdata_i[STAT_LSB +: N_EVT] & CLR_SET) : '0;
  assign arm_set   = ctl_wr & (reg_mode_i == MODE_SET) & reg_wdata_i[STAT_LSB+ARM_IDX];
  assign rst_start = wr_ok & (reg_addr_i == ADDR_CFG) & reg_wdata_i[RST_BIT];
  assign evt_eff   = evt_i & ~ARM_ONEHOT;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                mask_q <= '1;
    else if (busy)                              mask_q <= '1;
    else if (wr_ok && reg_addr_i == ADDR_MASK)  mask_q <= reg_wdata_i[N_EVT-1:0];
  end

  rxch_status_bank u_status (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .evt_i    (evt_eff),
    .clr_i    (stat_clr),
    .hold_i   (busy),
    .status_o (status_q)
  );

  assign active  = status_q & ~mask_q;
  assign fatal_o = |(active & FATAL_SET);

  rxch_arm_ctl u_arm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .set_i        (arm_set),
    .hold_i       (busy),
    .active_any_i (|active),
    .arm_o        (arm_q),
    .irq_o        (irq_o)
  );

  rxch_rst_seq #(.RST_CYCLES(RST_CYCLES)) u_rst (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (rst_start),
    .busy_o  (busy)
  );

  assign chan_rst_o = busy;

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      ADDR_CTL: begin
        reg_rdata_o[STAT_LSB +: N_EVT]     = status_q;
        reg_rdata_o[STAT_LSB + ARM_IDX]    = arm_q;
      end
      ADDR_MASK: reg_rdata_o[N_EVT-1:0]  = mask_q;
      ADDR_CFG:  reg_rdata_o[RST_BIT]    = busy;
      default:   reg_rdata_o             = '0;
    endcase
  end

  logic unused_wdata;
  assign unused_wdata = ^{reg_wdata_i[REG_W-1:STAT_LSB+N_EVT],
                          reg_wdata_i[STAT_LSB-1:RST_BIT+1],
                          reg_wdata_i[RST_BIT-1:N_EVT]};
endmodule

// File: rtl/rxch_intr_chk.sv
module rxch_intr_chk
  import rxch_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic [N_EVT-1:0] evt_i,
  input logic             reg_wr_i,
  input logic [1:0]       reg_addr_i,
  input logic             reg_mode_i,
  input logic [REG_W-1:0] reg_wdata_i,
  input logic             irq_o,
  input logic             chan_rst_o,
  input logic [N_EVT-1:0] status_q,
  input logic [N_EVT-1:0] mask_q,
  input logic             arm_q
);
  logic arm_wr;
  assign arm_wr = reg_wr_i && !chan_rst_o && reg_addr_i == 2'd0
                  && reg_mode_i == 1'b0 && reg_wdata_i[STAT_LSB+ARM_IDX];

  assert_evt_wins_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !chan_rst_o |=> ((($past(evt_i) & ~ARM_ONEHOT) & ~status_q) == '0));

  assert_fatal_sticky_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !chan_rst_o |=> (($past(status_q) & FATAL_SET & ~status_q) == '0));

  assert_one_shot_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !arm_wr) |=> !arm_q);

  assert_arm_by_write_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(arm_q) |-> $past(arm_wr));

  assert_rst_clears_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chan_rst_o |=> (status_q == '0 && mask_q == '1 && !arm_q && !irq_o));
endmodule

bind rxch_intr_ctl rxch_intr_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .evt_i       (evt_i),
  .reg_wr_i    (reg_wr_i),
  .reg_addr_i  (reg_addr_i),
  .reg_mode_i  (reg_mode_i),
  .reg_wdata_i (reg_wdata_i),
  .irq_o       (irq_o),
  .chan_rst_o  (chan_rst_o),
  .status_q    (status_q),
  .mask_q      (mask_q),
  .arm_q       (arm_q)
);

// File: tb/sim_rxch_intr_ctl.sv
`timescale 1ns/1ps
module sim_rxch_intr_ctl;
  localparam real CLK_HALF = 2.5;
  localparam int  RSTC     = 100;
  localparam logic [21:0] B_FATAL = 22'h3E1877;
  localparam logic [21:0] B_ARM   = 22'h008000;
  localparam logic [63:0] ARM_W   = 64'h0000_8000_0000_0000;

  typedef struct packed {
    logic [21:0] evt;
    logic [21:0] mask;
    logic        fat;
  } vec_t;

  localparam vec_t VEC [6] = '{
    '{evt: 22'h000001, mask: 22'h000000, fat: 1'b1},
    '{evt: 22'h000008, mask: 22'h000000, fat: 1'b0},
    '{evt: 22'h000001, mask: 22'h000001, fat: 1'b0},
    '{evt: 22'h006600, mask: 22'h000000, fat: 1'b0},
    '{evt: 22'h200000, mask: 22'h1FFFFF, fat: 1'b1},
    '{evt: 22'h008000, mask: 22'h000000, fat: 1'b0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [21:0] evt = '0;
  logic        wr = 1'b0;
  logic [1:0]  addr = '0;
  logic        mode = 1'b0;
  logic [63:0] wdata = '0;
  logic [63:0] rdata;
  logic        irq, fatal, crst;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #(CLK_HALF) clk = ~clk;

  rxch_intr_ctl #(.RST_CYCLES(RSTC)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .evt_i(evt), .reg_wr_i(wr), .reg_addr_i(addr),
    .reg_mode_i(mode), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .irq_o(irq), .fatal_o(fatal), .chan_rst_o(crst)
  );

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [63:0] v);
    addr = a;
    #0.5;
    v = rdata;
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic m, input logic [63:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; mode = m; wdata = d;
    @(negedge clk);
    wr = 1'b0; wdata = '0; mode = 1'b0;
  endtask

  task automatic pulse(input logic [21:0] e);
    @(negedge clk);
    evt = e;
    @(negedge clk);
    evt = '0;
  endtask

  task automatic chan_reset();
    wr_reg(2'd2, 1'b0, 64'h4000_0000);
    while (crst) @(negedge clk);
  endtask

  function automatic logic [63:0] stat_w(input logic [21:0] s, input logic a);
    return ({42'b0, s} << 32) | (a ? ARM_W : 64'b0);
  endfunction

  initial begin
    #(CLK_HALF * 2 * 150000);
    if (!done) begin
      done = 1;
      bad++; total++;
      $display("FAIL R10 watchdog got=hang exp=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [63:0] v;
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10 reset state
    rd(2'd0, v); chk("R10 status after reset", v, 64'h0);
    rd(2'd1, v); chk("R10 mask after reset", v, 64'h3FFFFF);
    rd(2'd2, v); chk("R10 config after reset", v, 64'h0);
    rd(2'd3, v); chk("R10 addr3 reads zero", v, 64'h0);
    chk("R10 irq/crst idle", {62'b0, irq, crst}, 64'h0);

    // table walk: R1 latch, R2 mask, R3 fatal, R4 clear
    foreach (VEC[k]) begin
      chan_reset();
      wr_reg(2'd1, 1'b0, {42'b0, VEC[k].mask});
      pulse(VEC[k].evt);
      rd(2'd0, v); chk($sformatf("R1 vec%0d status", k), v, stat_w(VEC[k].evt & ~B_ARM, 1'b0));
      chk($sformatf("R3 vec%0d fatal", k), {63'b0, fatal}, {63'b0, VEC[k].fat});
      chk($sformatf("R3 vec%0d model", k), {63'b0, fatal},
          {63'b0, |(VEC[k].evt & ~VEC[k].mask & B_FATAL)});
      wr_reg(2'd0, 1'b1, {10'b0, 22'h3FFFFF, 32'b0});
      rd(2'd0, v); chk($sformatf("R4 vec%0d after clear", k), v, stat_w(VEC[k].evt & B_FATAL, 1'b0));
    end

    // R7 one-shot interrupt
    chan_reset();
    wr_reg(2'd1, 1'b0, 64'h0);
    wr_reg(2'd0, 1'b0, ARM_W);
    rd(2'd0, v); chk("R6 arm set", v, ARM_W);
    chk("R7 no irq without event", {63'b0, irq}, 64'h0);
    pulse(22'h004000);
    chk("R7 irq fires", {63'b0, irq}, 64'h1);
    @(negedge clk);
    chk("R7 irq drops", {63'b0, irq}, 64'h0);
    rd(2'd0, v); chk("R7 arm self-cleared", v, stat_w(22'h004000, 1'b0));
    wr_reg(2'd0, 1'b0, ARM_W);
    chk("R7 re-arm with pending event", {63'b0, irq}, 64'h1);
    @(negedge clk);
    chk("R7 second shot ends", {63'b0, irq}, 64'h0);
    wr_reg(2'd0, 1'b1, {10'b0, 22'h004000, 32'b0});
    rd(2'd0, v); chk("R4 recoverable bit cleared", v, 64'h0);
    wr_reg(2'd0, 1'b0, ARM_W);
    rd(2'd0, v); chk("R7 armed, nothing pending", {v[63:1], irq}, {ARM_W[63:1], 1'b0});

    // R2 mask gating of irq
    wr_reg(2'd1, 1'b0, 64'h8);
    pulse(22'h000008);
    chk("R2 masked event no irq", {63'b0, irq}, 64'h0);
    rd(2'd0, v); chk("R2 masked status set, still armed", v, stat_w(22'h000008, 1'b1));
    wr_reg(2'd1, 1'b0, 64'h0);
    chk("R2 unmask raises irq", {63'b0, irq}, 64'h1);

    // R6 mode rules and evt_i[15]
    chan_reset();
    wr_reg(2'd0, 1'b1, ARM_W);
    rd(2'd0, v); chk("R6 mode1 bit47 no arm", v, 64'h0);
    wr_reg(2'd0, 1'b0, {10'b0, 22'h3F7FFF, 32'b0});
    rd(2'd0, v); chk("R6 mode0 no status set", v, 64'h0);
    pulse(22'h008000);
    rd(2'd0, v); chk("R6 evt15 ignored", v, 64'h0);

    // R5 event wins over same-cycle clear
    pulse(22'h000200);
    wr_reg(2'd0, 1'b0, 64'h0);
    rd(2'd0, v); chk("R6 mode0 zero keeps status", v, stat_w(22'h000200, 1'b0));
    @(negedge clk);
    evt = 22'h000200; wr = 1'b1; addr = 2'd0; mode = 1'b1; wdata = {10'b0, 22'h000200, 32'b0};
    @(negedge clk);
    evt = '0; wr = 1'b0; mode = 1'b0; wdata = '0;
    rd(2'd0, v); chk("R5 event beats clear", v, stat_w(22'h000200, 1'b0));
    wr_reg(2'd0, 1'b1, {10'b0, 22'h000200, 32'b0});
    rd(2'd0, v); chk("R4 clear alone works", v, 64'h0);
    wr_reg(2'd0, 1'b1, {10'b0, 22'h3FFFFF, 32'b0});
    pulse(22'h000002);
    wr_reg(2'd0, 1'b1, {10'b0, 22'h3FFFFF, 32'b0});
    rd(2'd0, v); chk("R4 fatal bit not cleared", v, stat_w(22'h000002, 1'b0));

    // R8/R9 channel reset window
    wr_reg(2'd0, 1'b0, ARM_W);
    wr_reg(2'd2, 1'b0, 64'h0);
    chk("R8 zero write no reset", {63'b0, crst}, 64'h0);
    wr_reg(2'd2, 1'b0, 64'h4000_0000);
    n = 0;
    while (crst && n < 1000) begin
      n++;
      if (n == 5) begin
        evt = 22'h3FFFFF; wr = 1'b1; addr = 2'd1; wdata = 64'h0;
      end else begin
        evt = '0; wr = 1'b0;
      end
      if (n == 10) begin
        rd(2'd2, v); chk("R8 reset bit reads 1", v, 64'h4000_0000);
      end
      @(negedge clk);
    end
    evt = '0; wr = 1'b0;
    chk("R8 reset length", 64'(n), 64'(RSTC));
    rd(2'd0, v); chk("R9 status/arm cleared", v, 64'h0);
    rd(2'd1, v); chk("R9 mask all ones", v, 64'h3FFFFF);
    rd(2'd2, v); chk("R8 reset bit self-clears", v, 64'h0);
    chk("R9 outputs quiet", {62'b0, irq, fatal}, 64'h0);

    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule